// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the raw serial pins of an SPI target and its command controller. It brings chip select, serial clock and the active-low pause input into the system clock domain. It then gives the controller one-cycle strobes for each qualified rising and falling serial clock edge. While the pause is in force, no strobes are issued. The controller's shift counters and state registers therefore stay frozen, and the transaction carries on from the same bit once the pause is released.

Entering and leaving the pause depends on the serial clock level. A pause request made while the clock is low takes effect at once. A request made while the clock is high waits for the next falling clock edge, and that edge is swallowed. A release counts only when the pause input is seen high while the clock is low. The block also drives the output enable for the serial data line. Deselecting the target always wins: it ends the transaction and clears any pause.

Top module: `spi_hold_gate`

## Requirements
- R1: In reset, and after reset while chip select is high, the rise strobe, the fall strobe, `paused_o` and `so_oe_o` are all 0.
- R2: With chip select low and no pause in force or being entered, each serial clock rising edge gives exactly one one-cycle `sck_rise_o` pulse and each falling edge gives exactly one `sck_fall_o` pulse. The two never pulse in the same cycle.
- R3: If the pause input is driven low while the serial clock is low, `paused_o` goes to 1 and later clock edges produce no strobes.
- R4: If the pause input is driven low while the serial clock is high, `paused_o` stays 0 until the next falling clock edge. That falling edge produces no fall strobe and sets `paused_o` to 1.
- R5: Driving the pause input high while the clock is low clears `paused_o`. The next rising clock edge produces a rise strobe.
- R6: If the pause input is driven high while the clock is high, `paused_o` stays 1. It clears at the next falling clock edge, which produces no fall strobe.
- R7: `so_oe_o` is 1 exactly when chip select is low, the pause input is high and `paused_o` is 0. It drops in the same cycle the synchronised pause input goes low.
- R8: Chip select going high during a pause clears `paused_o`. The next transaction starts unpaused if the pause input is high.
- R9: A deferred pause request is cancelled if the pause input returns high before the clock falls. That falling edge then gives a normal fall strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Raw chip select, active low |
| sck_i | input | 1 | Raw serial clock |
| hold_ni | input | 1 | Raw pause request, active low |
| sck_rise_o | output | 1 | Qualified rising edge strobe, one cycle |
| sck_fall_o | output | 1 | Qualified falling edge strobe, one cycle |
| so_oe_o | output | 1 | Serial data output enable |
| paused_o | output | 1 | Pause in force |

## Verification
The pause input can change in the same synchronised cycle as a serial clock edge. This happens most sharply when a pause request or release coincides with a falling edge. Whether that edge is swallowed, delivered, or ends the pause is decided entirely in that cycle. The bench provokes these collisions by changing several pins at the same clock edge in random steps, and also in directed steps. A bench model then judges each step by the clock level and the pause state before the change: it counts the expected strobes and predicts the pause and output enable levels.

// File: rtl/shg_pkg.sv
package shg_pkg;
  typedef enum logic [1:0] {
    HS_RUN    = 2'd0,
    HS_ARMED  = 2'd1,
    HS_FROZEN = 2'd2
  } hold_st_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned NUM_PINS = 3;
endpackage

// File: rtl/shg_sync.sv
module shg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = chain_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else         chain_q[s] <= src;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/shg_edge.sv
module shg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R2
endmodule

// File: rtl/shg_hold_fsm.sv
module shg_hold_fsm
  import shg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic pass_o,
  output logic frozen_o
);
  hold_st_e st_q, st_d;
  logic     entering;

  // pause begins this cycle: clock is low and a request is live
  assign entering = ~cs_n_i & ~hold_n_i & ~sck_i & (st_q != HS_FROZEN);

  always_comb begin
    st_d = st_q;
    if (cs_n_i) begin
      st_d = HS_RUN;
    end else begin
      unique case (st_q)
        HS_RUN: begin
          if (!hold_n_i) st_d = sck_i ? HS_ARMED : HS_FROZEN;
        end
        HS_ARMED: begin
          if (hold_n_i)    st_d = HS_RUN;
          else if (!sck_i) st_d = HS_FROZEN;
        end
        HS_FROZEN: begin
          if (hold_n_i && !sck_i) st_d = HS_RUN;
        end
        default: st_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= HS_RUN;
    else         st_q <= st_d;
  end

  assign pass_o   = ~cs_n_i & (st_q != HS_FROZEN) & ~entering;
  assign frozen_o = (st_q == HS_FROZEN);

  AST_ARMED_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != HS_FROZEN && sck_i && !cs_n_i) |=> (st_q != HS_FROZEN)); // R4
  AST_FROZEN_HIGH_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_FROZEN && sck_i && !cs_n_i) |=> (st_q == HS_FROZEN)); // R6
  AST_CS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (st_q == HS_RUN)); // R8
  AST_LOW_SCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !hold_n_i && !sck_i) |=> (st_q == HS_FROZEN)); // R3
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import shg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic so_oe_o,
  output logic paused_o
);
  localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'((1 << PIN_CS) | (1 << PIN_HOLD));

  logic [NUM_PINS-1:0] raw_pins, s_pins;
  logic s_cs_n, s_sck, s_hold_n;
  logic raw_rise, raw_fall, pass, frozen;

  always_comb begin
    raw_pins           = '0;
    raw_pins[PIN_CS]   = cs_ni;
    raw_pins[PIN_SCK]  = sck_i;
    raw_pins[PIN_HOLD] = hold_ni;
  end

  shg_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_pins), .q_o(s_pins)
  );

  assign s_cs_n   = s_pins[PIN_CS];
  assign s_sck    = s_pins[PIN_SCK];
  assign s_hold_n = s_pins[PIN_HOLD];

  shg_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(s_sck), .rise_o(raw_rise), .fall_o(raw_fall)
  );

  shg_hold_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(s_cs_n), .sck_i(s_sck),
    .hold_n_i(s_hold_n), .pass_o(pass), .frozen_o(frozen)
  );

  assign sck_rise_o = raw_rise & pass;
  assign sck_fall_o = raw_fall & pass;
  assign so_oe_o    = ~s_cs_n & s_hold_n & ~frozen;
  assign paused_o   = frozen;

  AST_NO_STROBE_PAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !(sck_rise_o || sck_fall_o)); // R3
  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_hold_n |-> !so_oe_o); // R7
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cs_n |-> !(sck_rise_o || sck_fall_o || so_oe_o)); // R1
endmodule

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, hold_ni = 1'b1;
  logic sck_rise_o, sck_fall_o, so_oe_o, paused_o;
  int   n_chk = 0, n_bad = 0, cyc = 0;
  int   cnt_r = 0, cnt_f = 0;
  // reference: 0 run, 1 armed, 2 frozen
  int   m_st = 0;
  logic m_sck = 1'b0;
  int   e_r = 0, e_f = 0;

  always #10 clk = ~clk;

  spi_hold_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .hold_ni(hold_ni),
    .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o), .so_oe_o(so_oe_o), .paused_o(paused_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (sck_rise_o) cnt_r++;
    if (sck_fall_o) cnt_f++;
  end

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // expected strobes from one step of pin changes
  function automatic void model(logic cs, logic sck, logic hold);
    logic r, f;
    r = sck & ~m_sck;
    f = ~sck & m_sck;
    if (cs) m_st = 0;
    else begin
      case (m_st)
        0: if (!hold) begin
             if (!sck) m_st = 2; else begin m_st = 1; e_r += int'(r); end
           end else begin e_r += int'(r); e_f += int'(f); end
        1: if (hold) begin m_st = 0; e_r += int'(r); e_f += int'(f); end
           else if (!sck) m_st = 2;
           else e_r += int'(r);
        default: if (hold && !sck) m_st = 0;
      endcase
    end
    m_sck = sck;
  endfunction

  task automatic step(logic cs, logic sck, logic hold, string req);
    @(negedge clk);
    cs_ni = cs; sck_i = sck; hold_ni = hold;
    model(cs, sck, hold);
    repeat (8) @(negedge clk);
    #1;
    check(req, "rise count", cnt_r, e_r);
    check(req, "fall count", cnt_f, e_f);
    check(req, "paused", int'(paused_o), int'(m_st == 2));
    check(req, "so_oe", int'(so_oe_o), int'(!cs && hold && m_st != 2));
  endtask

  initial begin : wdog
    wait (cyc >= 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got %0d expected 0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1", "rise in reset", int'(sck_rise_o), 0);
    check("R1", "paused in reset", int'(paused_o), 0);
    check("R1", "so_oe in reset", int'(so_oe_o), 0);
    rst_ni = 1'b1;
    step(1, 1, 1, "R1");
    step(1, 0, 1, "R1");
    // R2 plain edges
    step(0, 0, 1, "R7");
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, "R2");
      step(0, 0, 1, "R2");
    end
    // R3 immediate pause, edges ignored
    step(0, 0, 0, "R3");
    step(0, 1, 0, "R3");
    step(0, 0, 0, "R3");
    // R5 release while low, then edge counts
    step(0, 0, 1, "R5");
    step(0, 1, 1, "R5");
    // R4 deferred entry, falling edge swallowed
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R4");
    // R6 release while high stays paused
    step(0, 1, 0, "R6");
    step(0, 1, 1, "R6");
    step(0, 0, 1, "R6");
    // R9 deferred request cancelled
    step(0, 1, 1, "R9");
    step(0, 1, 0, "R9");
    step(0, 1, 1, "R9");
    step(0, 0, 1, "R9");
    // R8 abort by deselect during pause
    step(0, 0, 0, "R8");
    step(1, 0, 0, "R8");
    step(1, 0, 1, "R8");
    step(0, 0, 1, "R8");
    // collision: request and falling edge together
    step(0, 1, 1, "R4");
    step(0, 0, 0, "R4");
    step(0, 1, 1, "R6");
    step(0, 0, 1, "R6");
    // random mixes, several pins may move at once
    for (int i = 0; i < 400; i++) begin
      logic c, s, h;
      c = (($urandom % 8) == 0) ? ~cs_ni : cs_ni;
      s = (($urandom % 2) == 0) ? ~sck_i : sck_i;
      h = (($urandom % 4) == 0) ? ~hold_ni : hold_ni;
      step(c, s, h, "R2");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule